// File: doc/BRIEF.md
# Multi-Wide Register Rename Table

This block translates architectural register names into physical register IDs for a whole bundle of instructions in a single cycle. It holds one entry per architectural integer register, and each entry stores the physical register ID that currently holds that register's value. Every rename slot presents two source register names and, optionally, a destination name with a newly allocated physical ID. The block returns the physical IDs for both sources and the previous mapping of the destination. That previous mapping is what the commit logic later releases.

Instructions in one bundle may depend on each other. A source of a slot is therefore compared against the destinations of all earlier slots in the same bundle. When it matches, the source takes the newest such mapping and does not use the table contents. At the clock edge the table records the mapping of the last slot that writes each register. A restore port overwrites every entry at once so that recovery logic outside this block can roll the table back.

Top module: `rat_rename_map`

## Requirements
- R1: When reset is released, architectural register r maps to physical register r for every r in 0..15.
- R2: A source or old-mapping lookup with no matching earlier writer in the bundle returns the table entry as it stood at the start of the cycle.
- R3: A source of slot i that names the destination of an earlier writing slot j<i in the same bundle returns that slot's new physical ID.
- R4: When several earlier slots write the register a source names, the source returns the new ID of the highest-numbered of those slots.
- R5: A slot's own destination and the destinations of later slots never feed its sources or its old-mapping output.
- R6: After the edge, each register written in the bundle maps to the new ID of the highest-numbered slot that wrote it. Registers not written keep their entries.
- R7: The old-mapping output of a writing slot is the mapping its destination had just before that slot: an earlier same-bundle writer's new ID if one exists, otherwise the table entry.
- R8: A slot whose valid bit is 0, or whose destination-write flag is 0, neither changes the table nor forwards to later slots.
- R9: With the restore input at 1, all 16 entries take the values on the restore bus at the edge (entry r from bits 9r+8..9r), overriding any rename write in that cycle.
- R10: Lookup results are combinational in the inputs of the same cycle. Table updates become visible from the cycle after the edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slot_valid | input | WIDTH | Per-slot valid bit, bit i for slot i (slot 0 is oldest) |
| slot_src_a | input | 4*WIDTH | First source register, slot i in bits 4i+3..4i |
| slot_src_b | input | 4*WIDTH | Second source register, same packing |
| slot_dst_we | input | WIDTH | Per-slot destination-write flag |
| slot_dst | input | 4*WIDTH | Destination register, slot i in bits 4i+3..4i |
| slot_new_preg | input | 9*WIDTH | Newly allocated physical ID, slot i in bits 9i+8..9i |
| restore_en | input | 1 | Load the whole table from restore_map at the edge |
| restore_map | input | 144 | Restore image, entry r in bits 9r+8..9r |
| out_psrc_a | output | 9*WIDTH | Physical ID for the first source of each slot |
| out_psrc_b | output | 9*WIDTH | Physical ID for the second source of each slot |
| out_pold | output | 9*WIDTH | Prior mapping of each slot's destination |

## Verification
All three lookup outputs are combinational, so their expected values belong to the same cycle in which a bundle is driven. The bench drives a bundle just after a rising edge and samples at the next falling edge, which is before that bundle is committed. Table writes and restores take effect at the following rising edge. The reference map therefore advances only after that edge, and the next bundle's expectations come from the updated map, one cycle after the stimulus that changed it.

// File: rtl/rat_pkg.sv
package rat_pkg;

    localparam int ARCH_REGS  = 16;
    localparam int AREG_W     = $clog2(ARCH_REGS);
    localparam int PREG_COUNT = 512;
    localparam int PREG_W     = $clog2(PREG_COUNT);
    localparam int RENAME_W   = 6;

    typedef logic [AREG_W-1:0] areg_t;
    typedef logic [PREG_W-1:0] preg_t;

    // One rename slot as presented by the decode stage.
    typedef struct packed {
        logic  valid;
        areg_t src_a;
        areg_t src_b;
        logic  dst_we;
        areg_t dst;
        preg_t new_preg;
    } slot_req_t;

    // Lookup results for one slot.
    typedef struct packed {
        preg_t psrc_a;
        preg_t psrc_b;
        preg_t pold;
    } slot_res_t;

    // True when a slot really produces a new mapping for register r.
    function automatic logic slot_writes(slot_req_t s, areg_t r);
        return s.valid && s.dst_we && (s.dst == r);
    endfunction

endpackage

// File: rtl/rat_table.sv
module rat_table
    import rat_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  preg_t next_map [ARCH_REGS],
    output preg_t cur_map  [ARCH_REGS]
);

    preg_t map_q [ARCH_REGS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int r = 0; r < ARCH_REGS; r++) begin
                map_q[r] <= preg_t'(r);
            end
        end else begin
            for (int r = 0; r < ARCH_REGS; r++) begin
                map_q[r] <= next_map[r];
            end
        end
    end

    always_comb begin
        for (int r = 0; r < ARCH_REGS; r++) begin
            cur_map[r] = map_q[r];
        end
    end

endmodule

// File: rtl/rat_fwd_lookup.sv
module rat_fwd_lookup
    import rat_pkg::*;
#(
    parameter int WIDTH = RENAME_W,
    parameter int SLOT  = 0
) (
    input  preg_t     cur_map [ARCH_REGS],
    input  slot_req_t req     [WIDTH],
    input  areg_t     query,
    output preg_t     result
);

    // Walk the older slots from oldest to youngest; the last match wins.
    always_comb begin
        result = cur_map[query];
        for (int j = 0; j < SLOT; j++) begin
            if (slot_writes(req[j], query)) begin
                result = req[j].new_preg;
            end
        end
    end

endmodule

// File: rtl/rat_commit.sv
module rat_commit
    import rat_pkg::*;
#(
    parameter int WIDTH = RENAME_W
) (
    input  preg_t     cur_map     [ARCH_REGS],
    input  slot_req_t req         [WIDTH],
    input  logic      restore_en,
    input  preg_t     restore_img [ARCH_REGS],
    output preg_t     next_map    [ARCH_REGS]
);

    always_comb begin
        for (int r = 0; r < ARCH_REGS; r++) begin
            next_map[r] = cur_map[r];
            for (int j = 0; j < WIDTH; j++) begin
                if (slot_writes(req[j], areg_t'(r))) begin
                    next_map[r] = req[j].new_preg;
                end
            end
            if (restore_en) begin
                next_map[r] = restore_img[r];
            end
        end
    end

endmodule

// File: rtl/rat_rename_map.sv
module rat_rename_map
    import rat_pkg::*;
#(
    parameter int WIDTH = RENAME_W
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [WIDTH-1:0]            slot_valid,
    input  logic [WIDTH*AREG_W-1:0]     slot_src_a,
    input  logic [WIDTH*AREG_W-1:0]     slot_src_b,
    input  logic [WIDTH-1:0]            slot_dst_we,
    input  logic [WIDTH*AREG_W-1:0]     slot_dst,
    input  logic [WIDTH*PREG_W-1:0]     slot_new_preg,
    input  logic                        restore_en,
    input  logic [ARCH_REGS*PREG_W-1:0] restore_map,
    output logic [WIDTH*PREG_W-1:0]     out_psrc_a,
    output logic [WIDTH*PREG_W-1:0]     out_psrc_b,
    output logic [WIDTH*PREG_W-1:0]     out_pold
);

    slot_req_t req         [WIDTH];
    slot_res_t res         [WIDTH];
    preg_t     cur_map     [ARCH_REGS];
    preg_t     next_map    [ARCH_REGS];
    preg_t     restore_img [ARCH_REGS];

    // Unpack the flat port buses into per-slot records.
    for (genvar i = 0; i < WIDTH; i++) begin : g_unpack
        assign req[i].valid    = slot_valid[i];
        assign req[i].src_a    = slot_src_a[i*AREG_W +: AREG_W];
        assign req[i].src_b    = slot_src_b[i*AREG_W +: AREG_W];
        assign req[i].dst_we   = slot_dst_we[i];
        assign req[i].dst      = slot_dst[i*AREG_W +: AREG_W];
        assign req[i].new_preg = slot_new_preg[i*PREG_W +: PREG_W];
    end

    for (genvar r = 0; r < ARCH_REGS; r++) begin : g_restore
        assign restore_img[r] = restore_map[r*PREG_W +: PREG_W];
    end

    rat_table u_table (
        .clk      (clk),
        .rst      (rst),
        .next_map (next_map),
        .cur_map  (cur_map)
    );

    rat_commit #(.WIDTH(WIDTH)) u_commit (
        .cur_map     (cur_map),
        .req         (req),
        .restore_en  (restore_en),
        .restore_img (restore_img),
        .next_map    (next_map)
    );

    // Three forwarded lookups per slot; each sees only strictly older slots.
    for (genvar i = 0; i < WIDTH; i++) begin : g_slot
        rat_fwd_lookup #(.WIDTH(WIDTH), .SLOT(i)) u_src_a (
            .cur_map (cur_map),
            .req     (req),
            .query   (req[i].src_a),
            .result  (res[i].psrc_a)
        );
        rat_fwd_lookup #(.WIDTH(WIDTH), .SLOT(i)) u_src_b (
            .cur_map (cur_map),
            .req     (req),
            .query   (req[i].src_b),
            .result  (res[i].psrc_b)
        );
        rat_fwd_lookup #(.WIDTH(WIDTH), .SLOT(i)) u_old (
            .cur_map (cur_map),
            .req     (req),
            .query   (req[i].dst),
            .result  (res[i].pold)
        );

        assign out_psrc_a[i*PREG_W +: PREG_W] = res[i].psrc_a;
        assign out_psrc_b[i*PREG_W +: PREG_W] = res[i].psrc_b;
        assign out_pold[i*PREG_W +: PREG_W]   = res[i].pold;
    end

endmodule

// File: rtl/rat_rename_map_chk.sv
module rat_rename_map_chk
    import rat_pkg::*;
#(
    parameter int WIDTH = RENAME_W
) (
    input logic                        clk,
    input logic                        rst,
    input logic [WIDTH-1:0]            slot_valid,
    input logic [WIDTH*AREG_W-1:0]     slot_src_a,
    input logic [WIDTH-1:0]            slot_dst_we,
    input logic [WIDTH*AREG_W-1:0]     slot_dst,
    input logic [WIDTH*PREG_W-1:0]     slot_new_preg,
    input logic                        restore_en,
    input logic [ARCH_REGS*PREG_W-1:0] restore_map,
    input logic [WIDTH*PREG_W-1:0]     out_psrc_a,
    input logic [WIDTH*PREG_W-1:0]     out_pold
);

    localparam int LAST = WIDTH - 1;

    logic [ARCH_REGS*PREG_W-1:0] restore_map_q;
    always_ff @(posedge clk) begin
        restore_map_q <= restore_map;
    end

    // R1
    reset_identity_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> out_psrc_a[PREG_W-1:0] == PREG_W'(slot_src_a[AREG_W-1:0]));

    // R3
    fwd_slot1_chk: assert property (@(posedge clk) disable iff (rst)
        (slot_valid[0] && slot_dst_we[0] && slot_src_a[2*AREG_W-1:AREG_W] == slot_dst[AREG_W-1:0])
        |-> out_psrc_a[2*PREG_W-1:PREG_W] == slot_new_preg[PREG_W-1:0]);

    // R7
    old_map_fwd_chk: assert property (@(posedge clk) disable iff (rst)
        (slot_valid[0] && slot_dst_we[0] && slot_dst[2*AREG_W-1:AREG_W] == slot_dst[AREG_W-1:0])
        |-> out_pold[2*PREG_W-1:PREG_W] == slot_new_preg[PREG_W-1:0]);

    // R6
    youngest_commit_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(restore_en) && $past(slot_valid[LAST] && slot_dst_we[LAST])
         && slot_src_a[AREG_W-1:0] == $past(slot_dst[LAST*AREG_W +: AREG_W]))
        |-> out_psrc_a[PREG_W-1:0] == $past(slot_new_preg[LAST*PREG_W +: PREG_W]));

    // R9
    restore_load_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(restore_en))
        |-> out_psrc_a[PREG_W-1:0] == restore_map_q[slot_src_a[AREG_W-1:0]*PREG_W +: PREG_W]);

    // R8
    no_writer_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(restore_en) && $past((slot_valid & slot_dst_we) == '0)
         && $stable(slot_src_a[AREG_W-1:0]))
        |-> $stable(out_psrc_a[PREG_W-1:0]));

endmodule

bind rat_rename_map rat_rename_map_chk #(.WIDTH(WIDTH)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .slot_valid    (slot_valid),
    .slot_src_a    (slot_src_a),
    .slot_dst_we   (slot_dst_we),
    .slot_dst      (slot_dst),
    .slot_new_preg (slot_new_preg),
    .restore_en    (restore_en),
    .restore_map   (restore_map),
    .out_psrc_a    (out_psrc_a),
    .out_pold      (out_pold)
);

// File: tb/rat_rename_map_bench.sv
`timescale 1ns/1ps
module rat_rename_map_bench;
    import rat_pkg::*;

    localparam int W  = RENAME_W;
    localparam int NR = ARCH_REGS;

    logic                     clk = 1'b0;
    logic                     rst = 1'b1;
    logic [W-1:0]             slot_valid = '0;
    logic [W*AREG_W-1:0]      slot_src_a = '0;
    logic [W*AREG_W-1:0]      slot_src_b = '0;
    logic [W-1:0]             slot_dst_we = '0;
    logic [W*AREG_W-1:0]      slot_dst = '0;
    logic [W*PREG_W-1:0]      slot_new_preg = '0;
    logic                     restore_en = 1'b0;
    logic [NR*PREG_W-1:0]     restore_map = '0;
    logic [W*PREG_W-1:0]      out_psrc_a;
    logic [W*PREG_W-1:0]      out_psrc_b;
    logic [W*PREG_W-1:0]      out_pold;

    always #2.5 clk = ~clk;

    rat_rename_map u_rat_rename_map (
        .clk(clk), .rst(rst), .slot_valid(slot_valid), .slot_src_a(slot_src_a),
        .slot_src_b(slot_src_b), .slot_dst_we(slot_dst_we), .slot_dst(slot_dst),
        .slot_new_preg(slot_new_preg), .restore_en(restore_en), .restore_map(restore_map),
        .out_psrc_a(out_psrc_a), .out_psrc_b(out_psrc_b), .out_pold(out_pold)
    );

    typedef struct {
        int    slot;
        int    kind;   // 0 first source, 1 second source, 2 old mapping
        int    exp;
        string tag;
    } exp_t;

    exp_t q[$];
    int   n_tests = 0;
    int   n_fail  = 0;
    bit   done    = 0;

    int model [NR];
    int rest_img [NR];
    int b_v [W], b_sa [W], b_sb [W], b_we [W], b_d [W], b_n [W];

    // Monitor: pops every expectation at the falling edge of the cycle it belongs to.
    always @(negedge clk) begin
        while (q.size() > 0) begin
            exp_t e;
            int   act;
            e = q.pop_front();
            case (e.kind)
                0:       act = int'(out_psrc_a[e.slot*PREG_W +: PREG_W]);
                1:       act = int'(out_psrc_b[e.slot*PREG_W +: PREG_W]);
                default: act = int'(out_pold[e.slot*PREG_W +: PREG_W]);
            endcase
            n_tests++;
            if (act != e.exp) begin
                n_fail++;
                $display("FAIL %s slot %0d kind %0d: actual %0d expected %0d",
                         e.tag, e.slot, e.kind, act, e.exp);
            end
        end
    end

    task automatic clear_bundle();
        for (int i = 0; i < W; i++) begin
            b_v[i] = 0; b_sa[i] = 0; b_sb[i] = 0; b_we[i] = 0; b_d[i] = 0; b_n[i] = 0;
        end
    endtask

    task automatic set_slot(int i, int v, int sa, int sb, int we, int d, int n);
        b_v[i] = v; b_sa[i] = sa; b_sb[i] = sb; b_we[i] = we; b_d[i] = d; b_n[i] = n;
    endtask

    function automatic int expect_lookup(int slot, int areg);
        int val = model[areg];
        for (int j = 0; j < slot; j++) begin
            if (b_v[j] != 0 && b_we[j] != 0 && b_d[j] == areg) val = b_n[j];
        end
        return val;
    endfunction

    // Driver: called just after a rising edge; drives, queues expectations,
    // then steps over the committing edge and advances the reference map.
    task automatic run_bundle(string tag, bit do_restore);
        int nxt [NR];
        for (int i = 0; i < W; i++) begin
            slot_valid[i]                      = b_v[i][0];
            slot_dst_we[i]                     = b_we[i][0];
            slot_src_a[i*AREG_W +: AREG_W]     = b_sa[i][AREG_W-1:0];
            slot_src_b[i*AREG_W +: AREG_W]     = b_sb[i][AREG_W-1:0];
            slot_dst[i*AREG_W +: AREG_W]       = b_d[i][AREG_W-1:0];
            slot_new_preg[i*PREG_W +: PREG_W]  = b_n[i][PREG_W-1:0];
        end
        restore_en = do_restore;
        for (int r = 0; r < NR; r++) restore_map[r*PREG_W +: PREG_W] = rest_img[r][PREG_W-1:0];
        for (int i = 0; i < W; i++) begin
            if (b_v[i] != 0) begin
                q.push_back('{i, 0, expect_lookup(i, b_sa[i]), tag});
                q.push_back('{i, 1, expect_lookup(i, b_sb[i]), tag});
                if (b_we[i] != 0) q.push_back('{i, 2, expect_lookup(i, b_d[i]), tag});
            end
        end
        for (int r = 0; r < NR; r++) nxt[r] = model[r];
        for (int j = 0; j < W; j++) begin
            if (b_v[j] != 0 && b_we[j] != 0) nxt[b_d[j]] = b_n[j];
        end
        if (do_restore) begin
            for (int r = 0; r < NR; r++) nxt[r] = rest_img[r];
        end
        @(posedge clk);
        for (int r = 0; r < NR; r++) model[r] = nxt[r];
        #1;
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R10 watchdog expired: actual hung expected completion");
            finish_run();
        end
    end

    initial begin
        bit [31:0] lfsr = 32'h1ACE_B00C;
        for (int r = 0; r < NR; r++) begin
            model[r] = r;
            rest_img[r] = 0;
        end
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 / R2: identity after reset, no writers in the bundle.
        clear_bundle();
        for (int i = 0; i < W; i++) set_slot(i, 1, i, 15 - i, 0, 0, 0);
        run_bundle("R1", 0);

        // R3 / R4 / R7: chained writers of r0 inside one bundle.
        clear_bundle();
        set_slot(0, 1, 7, 6, 1, 0, 47);
        set_slot(1, 1, 0, 1, 1, 0, 51);
        set_slot(2, 1, 0, 0, 0, 0, 0);
        set_slot(3, 1, 3, 0, 1, 0, 60);
        set_slot(4, 1, 0, 2, 0, 0, 0);
        run_bundle("R4", 0);

        // R6 / R10: the youngest writer (60) is visible only from the next cycle.
        clear_bundle();
        set_slot(0, 1, 0, 1, 0, 0, 0);
        set_slot(3, 1, 2, 0, 1, 2, 99);
        run_bundle("R6", 0);

        // R5: a slot reading its own destination sees the table value.
        clear_bundle();
        set_slot(0, 1, 4, 4, 1, 4, 200);
        set_slot(1, 1, 5, 4, 1, 5, 201);
        set_slot(2, 1, 6, 6, 1, 6, 202);
        set_slot(3, 1, 5, 6, 0, 0, 0);
        run_bundle("R5", 0);

        // R8: invalid writer and non-writing slot do not forward or update.
        clear_bundle();
        set_slot(0, 0, 0, 0, 1, 9, 300);
        set_slot(1, 1, 9, 9, 0, 9, 301);
        set_slot(2, 1, 9, 10, 1, 10, 302);
        set_slot(3, 1, 9, 10, 1, 11, 303);
        run_bundle("R8", 0);
        clear_bundle();
        set_slot(0, 1, 9, 11, 0, 0, 0);
        set_slot(5, 1, 10, 9, 1, 9, 310);
        run_bundle("R8", 0);

        // R9: restore overrides simultaneous writes.
        for (int r = 0; r < NR; r++) rest_img[r] = 100 + 3 * r;
        clear_bundle();
        set_slot(0, 1, 1, 2, 1, 1, 400);
        set_slot(5, 1, 3, 1, 1, 3, 401);
        run_bundle("R9", 1);
        clear_bundle();
        for (int i = 0; i < W; i++) set_slot(i, 1, i, i + 8, 0, 0, 0);
        run_bundle("R9", 0);
        clear_bundle();
        set_slot(0, 1, 1, 3, 0, 0, 0);
        set_slot(1, 1, 14, 15, 0, 0, 0);
        run_bundle("R9", 0);

        // R2 / R3 / R4: pseudo-random bundles with occasional restores.
        for (int t = 0; t < 60; t++) begin
            clear_bundle();
            for (int i = 0; i < W; i++) begin
                lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
                lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
                set_slot(i, int'(lfsr[0] | lfsr[1]), int'(lfsr[5:4]), int'(lfsr[9:8]),
                         int'(lfsr[2]), int'(lfsr[13:12]), int'(lfsr[28:20]));
            end
            if (t % 17 == 16) begin
                for (int r = 0; r < NR; r++) rest_img[r] = (t * 7 + r * 31) % 512;
                run_bundle("R3", 1);
            end else begin
                run_bundle("R3", 0);
            end
        end

        @(negedge clk);
        #1;
        done = 1;
        finish_run();
    end

endmodule